// File: doc/BRIEF.md
# Windowed Watchdog with Postscaler

This block is a watchdog timer that software must service with a clear strobe before a programmable period runs out. If no clear arrives in time, the block raises a one-cycle timeout event. The period is a base number of watchdog ticks, set by parameter, stretched by a power-of-two postscaler chosen by a 5-bit code. Counting is driven by one of two tick-enable inputs, one from the peripheral bus clock domain and one from a low-power RC source. Both arrive already brought into the block's single clock domain. The clock sources and reset generation sit outside the block.

In standard mode a clear is accepted at any point of the period. In windowed mode a clear is accepted only in the last part of the period. The size of that part is one of four fractions. A clear that comes too early raises a one-cycle window-violation event, which the surrounding logic treats like a timeout. Either event, and every accepted clear, restarts the period from zero. The watchdog runs when either the configuration enable or the software enable is set. Counting can optionally freeze while flash programming is in progress.

Top module: `windowed_watchdog`

## Requirements
- R1: With postscale code p, the timeout event rises after BASE_TICKS × 2^p counting ticks with no clear. It is a one-cycle pulse on the clock edge that consumes the last tick, and counting then restarts from zero.
- R2: A postscale code above POST_MAX_CODE (default 20) behaves exactly as code POST_MAX_CODE.
- R3: In windowed mode (cfg_std = 0), the window opens after a number of counted base steps set by cfg_win: code 00 gives BASE_TICKS/4 (75 % window), 01 gives BASE_TICKS/2 (50 %), 10 gives 5·BASE_TICKS/8 (37.5 %) and 11 gives 3·BASE_TICKS/4 (25 %). A clear while fewer base steps have elapsed raises win_viol for one cycle, on the cycle after the clear.
- R4: A clear that is accepted (the window is open, or standard mode) raises no event. It restarts both the base count and the postscaler, so the next timeout comes a full period after the clear.
- R5: With cfg_std = 1, a clear never raises win_viol, even when it comes immediately after the period starts.
- R6: The watchdog runs when cfg_on = 1 or sw_en = 1. While neither is set, the count is held at zero and no event is raised.
- R7: With cfg_stop_pgm = 1, no tick is counted while flash_busy = 1. With cfg_stop_pgm = 0, flash_busy has no effect.
- R8: cfg_src 00 counts tick_bus and cfg_src 11 counts tick_lp. The unused codes 01 and 10 count nothing.
- R9: A clear has priority over a terminal tick in the same cycle, and timeout and win_viol are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_bus | input | 1 | Tick enable from the peripheral bus clock source |
| tick_lp | input | 1 | Tick enable from the low-power RC source |
| cfg_src | input | 2 | Tick source select (00 bus, 11 low-power) |
| cfg_post | input | 5 | Postscale code, divide by 2^code |
| cfg_win | input | 2 | Window-size code |
| cfg_std | input | 1 | 1 = standard mode, 0 = windowed mode |
| cfg_on | input | 1 | Configuration enable, forces the watchdog on |
| cfg_stop_pgm | input | 1 | 1 = freeze counting while flash programming is busy |
| sw_en | input | 1 | Software enable, used when cfg_on is 0 |
| flash_busy | input | 1 | Flash programming in progress |
| clr | input | 1 | Watchdog clear strobe |
| timeout | output | 1 | One-cycle timeout event |
| win_viol | output | 1 | One-cycle window-violation event |

## Verification
The hardest case to reach is a clear that lands on exactly the clock edge where the last base step would fire. Being one cycle early or late turns it into an ordinary legal clear or a plain timeout. The bench reaches it by disabling the watchdog for one cycle, so the count returns to a known zero. It then enables counting on a tick every cycle and raises the clear a counted number of edges later, so the count at the clear is known exactly. The same counted-restart method puts clears one step either side of each of the four window openings. A behavioural model checks every cycle against the free-running low-power tick pattern.

// File: rtl/wdt_pkg.sv
// Package: shared types and helpers for the windowed watchdog.
// Assumes the base period is a multiple of 8 so every window fraction is exact.
package wdt_pkg;

    typedef enum logic [1:0] {
        SRC_BUS    = 2'b00,
        SRC_RSV_A  = 2'b01,
        SRC_RSV_B  = 2'b10,
        SRC_LOWPWR = 2'b11
    } wdt_src_e;

    // Number of base steps that must elapse before a clear is legal.
    function automatic int unsigned open_steps(int unsigned base, logic [1:0] code);
        case (code)
            2'b00:   return base / 4;
            2'b01:   return base / 2;
            2'b10:   return (base * 5) / 8;
            default: return (base * 3) / 4;
        endcase
    endfunction

endpackage

// File: rtl/wdt_advance.sv
// Module: wdt_advance
// Chooses the counting tick from the selected source and gates it with the
// run condition and the flash-programming freeze. Purely combinational.
// Assumes both tick inputs are single-cycle enables in the block clock domain.
module wdt_advance
    import wdt_pkg::*;
(
    input  logic       tick_bus,
    input  logic       tick_lp,
    input  logic [1:0] src,
    input  logic       run,
    input  logic       stop_pgm,
    input  logic       flash_busy,
    output logic       adv
);

    logic src_tick;
    logic frozen;

    // Select the tick of the configured source; reserved codes give none.
    always_comb begin
        case (wdt_src_e'(src))
            SRC_BUS:    src_tick = tick_bus;
            SRC_LOWPWR: src_tick = tick_lp;
            default:    src_tick = 1'b0;
        endcase
    end

    // Freeze applies only when stop-during-programming is configured.
    always_comb frozen = stop_pgm & flash_busy;

    // Final advance strobe.
    always_comb adv = run & src_tick & ~frozen;

endmodule

// File: rtl/wdt_postscaler.sv
// Module: wdt_postscaler
// Divides the advance strobe by 2^code. Emits one step per 2^code advances.
// Codes above MAX_CODE are clamped. A restart or a stopped watchdog clears
// the count. Assumes MAX_CODE >= 1.
module wdt_postscaler #(
    parameter int MAX_CODE = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          adv,
    input  logic          restart,
    input  logic [4:0]    code,
    output logic          step
);

    localparam int CW = MAX_CODE;

    logic [4:0]    eff_code;
    logic [CW-1:0] mask;
    logic [CW-1:0] post_cnt;
    logic          term;

    // Clamp the code to the largest supported divide ratio.
    always_comb eff_code = (int'(code) > MAX_CODE) ? 5'(MAX_CODE) : code;

    // Build the terminal mask one bit per stage: bit i is in use when i < code.
    for (genvar gi = 0; gi < CW; gi++) begin : g_mask
        assign mask[gi] = (gi < int'(eff_code));
    end

    // Terminal when every in-use low bit is set.
    always_comb term = ((post_cnt & mask) == mask);

    // A step leaves the postscaler on the advance that completes a group.
    always_comb step = adv & term;

    // Postscaler count register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            post_cnt <= '0;
        end else if (adv) begin
            post_cnt <= term ? '0 : post_cnt + 1'b1;
        end
    end

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !adv) |=> $stable(post_cnt)); // R7

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (post_cnt == '0)); // R6

endmodule

// File: rtl/wdt_window_counter.sv
// Module: wdt_window_counter
// Counts postscaled steps up to the base period and raises the timeout
// event. It checks each clear against the window opening and raises the
// window-violation event for an early clear. Any clear restarts the period.
// Assumes BASE_TICKS is a multiple of 8 and at least 8.
module wdt_window_counter
    import wdt_pkg::*;
#(
    parameter int BASE_TICKS = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       step,
    input  logic       clr,
    input  logic       windowed,
    input  logic [1:0] win_code,
    output logic       restart,
    output logic       timeout,
    output logic       win_viol
);

    localparam int CW = $clog2(BASE_TICKS);
    localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] open_at;
    logic          early;

    // Window opening for the selected size.
    always_comb open_at = CW'(open_steps(BASE_TICKS, win_code));

    // A clear is early when windowed and the window has not opened.
    always_comb early = windowed & (cnt < open_at);

    // Every clear while running restarts the postscaler too.
    always_comb restart = run & clr;

    // Base count and event registers; clear takes priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            timeout  <= 1'b0;
            win_viol <= 1'b0;
        end else begin
            timeout  <= 1'b0;
            win_viol <= 1'b0;
            if (clr) begin
                cnt      <= '0;
                win_viol <= early;
            end else if (step) begin
                if (cnt == LAST) begin
                    cnt     <= '0;
                    timeout <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_TIMEOUT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (cnt == '0)); // R1

    AST_VIOL_WINDOWED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        win_viol |-> ($past(windowed) && $past(clr))); // R5

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({timeout, win_viol})); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (!timeout && !win_viol)); // R6

endmodule

// File: rtl/windowed_watchdog.sv
// Module: windowed_watchdog (top)
// A watchdog with a selectable tick source, a power-of-two postscaler, an
// optional flash-programming freeze and standard or windowed clearing.
// Assumes the tick inputs are already in the clk domain.
module windowed_watchdog #(
    parameter int BASE_TICKS    = 256,
    parameter int POST_MAX_CODE = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_bus,
    input  logic       tick_lp,
    input  logic [1:0] cfg_src,
    input  logic [4:0] cfg_post,
    input  logic [1:0] cfg_win,
    input  logic       cfg_std,
    input  logic       cfg_on,
    input  logic       cfg_stop_pgm,
    input  logic       sw_en,
    input  logic       flash_busy,
    input  logic       clr,
    output logic       timeout,
    output logic       win_viol
);

    logic run;
    logic adv;
    logic step;
    logic restart;

    // The watchdog runs if forced on by configuration or enabled by software.
    always_comb run = cfg_on | sw_en;

    wdt_advance u_adv (
        .tick_bus   (tick_bus),
        .tick_lp    (tick_lp),
        .src        (cfg_src),
        .run        (run),
        .stop_pgm   (cfg_stop_pgm),
        .flash_busy (flash_busy),
        .adv        (adv)
    );

    wdt_postscaler #(.MAX_CODE(POST_MAX_CODE)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .adv     (adv),
        .restart (restart),
        .code    (cfg_post),
        .step    (step)
    );

    wdt_window_counter #(.BASE_TICKS(BASE_TICKS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .step     (step),
        .clr      (clr),
        .windowed (~cfg_std),
        .win_code (cfg_win),
        .restart  (restart),
        .timeout  (timeout),
        .win_viol (win_viol)
    );

endmodule

// File: tb/windowed_watchdog_test.sv
module windowed_watchdog_test;

    localparam int BASE = 8;
    localparam int PMAX = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_bus = 1'b1;
    logic       tick_lp = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic [4:0] cfg_post = 5'd0;
    logic [1:0] cfg_win = 2'b00;
    logic       cfg_std = 1'b1;
    logic       cfg_on = 1'b0;
    logic       cfg_stop_pgm = 1'b0;
    logic       sw_en = 1'b0;
    logic       flash_busy = 1'b0;
    logic       clr = 1'b0;
    logic       timeout;
    logic       win_viol;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    windowed_watchdog #(.BASE_TICKS(BASE), .POST_MAX_CODE(PMAX)) uut (
        .clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .tick_lp(tick_lp),
        .cfg_src(cfg_src), .cfg_post(cfg_post), .cfg_win(cfg_win),
        .cfg_std(cfg_std), .cfg_on(cfg_on), .cfg_stop_pgm(cfg_stop_pgm),
        .sw_en(sw_en), .flash_busy(flash_busy), .clr(clr),
        .timeout(timeout), .win_viol(win_viol)
    );

    always #5 clk = ~clk;

    // Free-running low-power tick: one tick every second cycle.
    always @(negedge clk) tick_lp <= ~tick_lp;

    // Behavioural reference model.
    int m_post = 0;
    int m_cnt = 0;
    bit e_to = 1'b0;
    bit e_wv = 1'b0;

    function automatic int open_of(logic [1:0] c);
        case (c)
            2'b00: return BASE / 4;
            2'b01: return BASE / 2;
            2'b10: return BASE * 5 / 8;
            default: return BASE * 3 / 4;
        endcase
    endfunction

    always @(posedge clk) begin
        int  p;
        int  m;
        bit  tk;
        bit  adv;
        bit  stp;
        if (!rst_n || !(cfg_on || sw_en)) begin
            m_post = 0; m_cnt = 0; e_to = 0; e_wv = 0;
        end else begin
            e_to = 0; e_wv = 0;
            p = (cfg_post > PMAX) ? PMAX : int'(cfg_post);
            m = (1 << p) - 1;
            tk = (cfg_src == 2'b00) ? tick_bus : (cfg_src == 2'b11) ? tick_lp : 1'b0;
            adv = tk && !(cfg_stop_pgm && flash_busy);
            stp = adv && ((m_post & m) == m);
            if (clr) begin
                e_wv = !cfg_std && (m_cnt < open_of(cfg_win));
                m_cnt = 0; m_post = 0;
            end else begin
                if (adv) m_post = stp ? 0 : m_post + 1;
                if (stp) begin
                    if (m_cnt == BASE - 1) begin m_cnt = 0; e_to = 1; end
                    else m_cnt = m_cnt + 1;
                end
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R1/R3 model timeout", int'(timeout), int'(e_to));
            check("R3/R9 model win_viol", int'(win_viol), int'(e_wv));
        end
    end

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            report();
        end
    end

    // Stop for one cycle so the count returns to zero, then start running.
    task automatic restart_run(bit on, bit sw);
        @(negedge clk);
        cfg_on = 1'b0; sw_en = 1'b0; clr = 1'b0;
        @(negedge clk);
        cfg_on = on; sw_en = sw;
    endtask

    // Return the negedge index at which timeout is seen, or -1 if none by lim.
    task automatic wait_to(int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (timeout && n < 0) begin n = i; break; end
        end
    endtask

    // Clear after k counted steps, return win_viol and timeout on the next cycle.
    task automatic clear_after(int k, output int wv, output int to);
        repeat (k) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        wv = int'(win_viol);
        to = int'(timeout);
    endtask

    initial begin
        int n;
        int wv;
        int to;
        repeat (3) @(negedge clk);
        check("R6 reset timeout", int'(timeout), 0);
        check("R6 reset win_viol", int'(win_viol), 0);
        rst_n = 1'b1;

        // R1 basic period
        cfg_post = 5'd0; cfg_std = 1'b1;
        restart_run(1, 0);
        wait_to(40, n); check("R1 period p=0", n, BASE);
        @(negedge clk); check("R1 one-cycle pulse", int'(timeout), 0);
        cfg_post = 5'd2;
        restart_run(1, 0);
        wait_to(100, n); check("R1 period p=2", n, BASE * 4);

        // R2 clamp
        cfg_post = 5'd31;
        restart_run(1, 0);
        wait_to(1000, n); check("R2 code 31 clamps", n, BASE * (1 << PMAX));
        cfg_post = 5'd0;

        // R6 enables
        restart_run(0, 0);
        wait_to(60, n); check("R6 disabled no timeout", n, -1);
        restart_run(0, 1);
        wait_to(40, n); check("R6 software enable", n, BASE);

        // R7 freeze
        cfg_stop_pgm = 1'b1; flash_busy = 1'b1;
        restart_run(1, 0);
        wait_to(5, n); check("R7 frozen while busy", n, -1);
        flash_busy = 1'b0;
        wait_to(40, n); check("R7 resumes after busy", n, BASE);
        cfg_stop_pgm = 1'b0; flash_busy = 1'b1;
        restart_run(1, 0);
        wait_to(40, n); check("R7 busy ignored", n, BASE);
        flash_busy = 1'b0;

        // R8 source select
        cfg_src = 2'b01;
        restart_run(1, 0);
        wait_to(40, n); check("R8 reserved 01 counts nothing", n, -1);
        cfg_src = 2'b10;
        restart_run(1, 0);
        wait_to(40, n); check("R8 reserved 10 counts nothing", n, -1);
        cfg_src = 2'b11;
        restart_run(1, 0);
        wait_to(40, n);
        check("R8 low-power source", int'(n >= 2 * BASE - 1 && n <= 2 * BASE + 1), 1);
        cfg_src = 2'b00;

        // R3 window openings, one step either side
        cfg_std = 1'b0;
        for (int c = 0; c < 4; c++) begin
            cfg_win = 2'(c);
            restart_run(1, 0);
            clear_after(open_of(2'(c)) - 1, wv, to);
            check($sformatf("R3 early clear code %0d", c), wv, 1);
            restart_run(1, 0);
            clear_after(open_of(2'(c)), wv, to);
            check($sformatf("R4 legal clear code %0d", c), wv, 0);
        end

        // R4 full period after a legal clear
        cfg_win = 2'b11;
        restart_run(1, 0);
        clear_after(BASE * 3 / 4, wv, to);
        wait_to(40, n); check("R4 restart after clear", n, BASE);

        // R9 clear on the terminal edge
        restart_run(1, 0);
        clear_after(BASE - 1, wv, to);
        check("R9 clear beats timeout", to, 0);
        check("R9 no violation at end", wv, 0);
        wait_to(40, n); check("R9 period restarted", n, BASE);

        // R5 standard mode never violates
        cfg_std = 1'b1; cfg_win = 2'b11;
        restart_run(1, 0);
        clear_after(0, wv, to); check("R5 immediate clear", wv, 0);
        clear_after(1, wv, to); check("R5 early clear", wv, 0);
        cfg_std = 1'b1;
        restart_run(1, 0);
        clear_after(BASE - 1, wv, to);
        check("R9 standard terminal clear", to, 0);

        repeat (4) @(negedge clk);
        report();
    end

endmodule